// File: doc/BRIEF.md
# Prescaled 54-bit Alarm Timer

A single timer channel for a larger chip. A 54-bit counter advances by one step each time a programmable prescaler completes its division period. It counts up or down and wraps modulo 2^54 in both directions. Software writes a 54-bit start value as two halves and then triggers a copy of it into the counter. Reading the counter is a two-step affair: software requests a snapshot, and the live count is then frozen into two readable halves. A 54-bit comparator raises a level interrupt when the armed alarm value is reached. The alarm either disarms itself or, in periodic mode, reloads the counter from the start value.

Software reaches the block through a single-cycle write strobe with a 4-bit word address. Read data is combinational on the same address. Register words:

| Address | Contents |
|---|---|
| 0 | control |
| 1 | snapshot request / busy |
| 2, 3 | snapshot low / high |
| 4, 5 | start value low / high |
| 6 | start trigger |
| 7, 8 | alarm low / high |
| 9 | raw status |
| 10 | interrupt enable |
| 11 | status clear |

High halves hold 22 bits, in bits 21:0.

Top module: `alarm_timer`

## Requirements
- R1: After reset every register reads zero, the counter is zero, and `irq` is low.
- R2: Writes to addresses 4 and 5 hold the start value. Only bits 21:0 of the high half are kept, and the same holds for the alarm high half at address 8. Any write to address 6 copies the start value into the counter at that clock edge.
- R3: Writing bit 0 = 1 to address 1 sets a busy flag, which reads back as bit 0 of address 1 for exactly one cycle. At the following edge the live counter is copied into addresses 2 and 3. The snapshot registers keep their old value until then.
- R4: Control bits 31:16 choose the divisor: 0 selects 65536, 1 and 2 both select 2, and any other N selects N. While run (control bit 0) is set, the counter steps once every divisor cycles. Clearing run restarts the prescaler from zero.
- R5: Control bit 1 = 1 counts up and 0 counts down. Both directions wrap modulo 2^54.
- R6: Control bit 3 arms the alarm. While it is armed and the counter equals the alarm value, the next edge sets the raw status bit (address 9, bit 0). Without periodic mode, that same edge clears bit 3 and the counter keeps stepping.
- R7: With periodic mode (control bit 2), the match edge reloads the counter from the start value instead of stepping, and bit 3 stays set.
- R8: `irq` is the level AND of raw status and enable (address 10, bit 0). Writing bit 0 = 1 to address 11 clears raw status. A simultaneous alarm match takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A prescaler phase error shows up as a snapshot value that is off by one step after a timed run segment, visible within a single divisor period. A wrong arm or compare state appears one edge after the match, either as raw status and `irq`, or as the arm bit readable in the control word. A bad reload decision corrupts the counter value that the next snapshot exposes.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package: register word addresses and control field positions for the alarm timer.
// Assumes a 4-bit word address and a 32-bit data bus.
package tmr_pkg;
    localparam int AW = 4;
    localparam logic [AW-1:0] A_CTRL  = 4'd0;
    localparam logic [AW-1:0] A_SNAP  = 4'd1;
    localparam logic [AW-1:0] A_CNTLO = 4'd2;
    localparam logic [AW-1:0] A_CNTHI = 4'd3;
    localparam logic [AW-1:0] A_LDLO  = 4'd4;
    localparam logic [AW-1:0] A_LDHI  = 4'd5;
    localparam logic [AW-1:0] A_LDGO  = 4'd6;
    localparam logic [AW-1:0] A_ALMLO = 4'd7;
    localparam logic [AW-1:0] A_ALMHI = 4'd8;
    localparam logic [AW-1:0] A_RAW   = 4'd9;
    localparam logic [AW-1:0] A_IEN   = 4'd10;
    localparam logic [AW-1:0] A_ICLR  = 4'd11;
    localparam int CTL_RUN  = 0;
    localparam int CTL_UP   = 1;
    localparam int CTL_AUTO = 2;
    localparam int CTL_ARM  = 3;
    localparam int PSC_LSB  = 16;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Prescaler: decodes the divisor field and emits a one-cycle tick every divisor cycles.
// Assumes run is a registered level; phase restarts from zero whenever run is low.
module tmr_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] field,
    output logic          tick
);
    localparam logic [PW:0] FULL = (PW+1)'(1) << PW;
    localparam logic [PW:0] TWO  = (PW+1)'(2);

    logic [PW:0] div;
    logic [PW:0] pc_q;
    logic        last;

    // Map the field to a divisor: zero is the full range, one is folded onto two.
    always_comb begin
        if (field == '0)               div = FULL;
        else if (field == PW'(1))      div = TWO;
        else                           div = {1'b0, field};
    end

    assign last = (pc_q >= div - (PW+1)'(1));
    assign tick = run && last;

    // Phase counter: hold at zero while stopped, wrap after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= '0;
        else if (!run)     pc_q <= '0;
        else if (last)     pc_q <= '0;
        else               pc_q <= pc_q + (PW+1)'(1);
    end

    // R4
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pc_q == '0);
    // R4
    stop_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pc_q == '0);
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
// Core: 54-bit up/down counter, start-value load, alarm compare, arm state and periodic reload.
// Assumes tick lasts one cycle; a load trigger outranks reload, and reload outranks a step.
module tmr_core #(
    parameter int CW = 54
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          up,
    input  logic          autorl,
    input  logic          ld_go,
    input  logic [CW-1:0] ld_val,
    input  logic [CW-1:0] alm_val,
    input  logic          arm_wr,
    input  logic          arm_wdata,
    output logic [CW-1:0] cnt,
    output logic          arm,
    output logic          hit
);
    logic [CW-1:0] cnt_q;
    logic          arm_q;

    assign hit = arm_q && (cnt_q == alm_val);
    assign cnt = cnt_q;
    assign arm = arm_q;

    // Counter update: load trigger, then periodic reload, then a prescaled step.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (ld_go)          cnt_q <= ld_val;
        else if (hit && autorl)  cnt_q <= ld_val;
        else if (tick)           cnt_q <= up ? cnt_q + CW'(1) : cnt_q - CW'(1);
    end

    // Arm state: a one-shot match disarms, otherwise software writes it.
    always_ff @(posedge clk) begin
        if (!rst_n)              arm_q <= 1'b0;
        else if (hit && !autorl) arm_q <= 1'b0;
        else if (arm_wr)         arm_q <= arm_wdata;
    end

    // R6
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !autorl) |=> !arm_q);
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && autorl && !ld_go) |=> cnt_q == $past(ld_val));
    // R5
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !hit && !ld_go && cnt_q == {CW{1'b1}}) |=> cnt_q == '0);
    // R5
    wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up && !hit && !ld_go && cnt_q == '0) |=> cnt_q == {CW{1'b1}});
endmodule

// File: rtl/alarm_timer.sv
`timescale 1ns/1ps
// Top: register file, snapshot path and interrupt status around the prescaler and core.
// Assumes single-cycle writes; read data is combinational on bus_addr.
module alarm_timer #(
    parameter int CW = 54,
    parameter int BW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [3:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic          irq
);
    import tmr_pkg::*;
    localparam int HW = CW - BW;

    logic          run_q, up_q, auto_q, ien_q, raw_q, busy_q;
    logic [PW-1:0] psc_q;
    logic [BW-1:0] ld_lo_q, alm_lo_q, snap_lo_q;
    logic [HW-1:0] ld_hi_q, alm_hi_q, snap_hi_q;
    logic          tick, hit, arm;
    logic [CW-1:0] cnt;
    logic          wr_ctrl, wr_iclr;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_iclr = bus_we && (bus_addr == A_ICLR);

    tmr_prescaler #(.PW(PW)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .field(psc_q), .tick(tick)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .up(up_q), .autorl(auto_q),
        .ld_go(bus_we && (bus_addr == A_LDGO)),
        .ld_val({ld_hi_q, ld_lo_q}), .alm_val({alm_hi_q, alm_lo_q}),
        .arm_wr(wr_ctrl), .arm_wdata(bus_wdata[CTL_ARM]),
        .cnt(cnt), .arm(arm), .hit(hit)
    );

    // Software-written configuration, start value and alarm value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; up_q <= 1'b0; auto_q <= 1'b0; psc_q <= '0; ien_q <= 1'b0;
            ld_lo_q <= '0; ld_hi_q <= '0; alm_lo_q <= '0; alm_hi_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_CTRL: begin
                    run_q  <= bus_wdata[CTL_RUN];
                    up_q   <= bus_wdata[CTL_UP];
                    auto_q <= bus_wdata[CTL_AUTO];
                    psc_q  <= bus_wdata[PSC_LSB +: PW];
                end
                A_LDLO:  ld_lo_q  <= bus_wdata;
                A_LDHI:  ld_hi_q  <= bus_wdata[HW-1:0];
                A_ALMLO: alm_lo_q <= bus_wdata;
                A_ALMHI: alm_hi_q <= bus_wdata[HW-1:0];
                A_IEN:   ien_q    <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Snapshot: a request raises busy, the next edge captures and drops busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; snap_lo_q <= '0; snap_hi_q <= '0;
        end else if (busy_q) begin
            busy_q    <= 1'b0;
            snap_lo_q <= cnt[BW-1:0];
            snap_hi_q <= cnt[CW-1:BW];
        end else if (bus_we && bus_addr == A_SNAP && bus_wdata[0]) begin
            busy_q <= 1'b1;
        end
    end

    // Raw status: alarm match sets it ahead of a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       raw_q <= 1'b0;
        else if (hit)                     raw_q <= 1'b1;
        else if (wr_iclr && bus_wdata[0]) raw_q <= 1'b0;
    end

    assign irq = raw_q && ien_q;

    // Read multiplexer over the register words.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTL_RUN]        = run_q;
                bus_rdata[CTL_UP]         = up_q;
                bus_rdata[CTL_AUTO]       = auto_q;
                bus_rdata[CTL_ARM]        = arm;
                bus_rdata[PSC_LSB +: PW]  = psc_q;
            end
            A_SNAP:  bus_rdata[0]      = busy_q;
            A_CNTLO: bus_rdata         = snap_lo_q;
            A_CNTHI: bus_rdata[HW-1:0] = snap_hi_q;
            A_LDLO:  bus_rdata         = ld_lo_q;
            A_LDHI:  bus_rdata[HW-1:0] = ld_hi_q;
            A_ALMLO: bus_rdata         = alm_lo_q;
            A_ALMHI: bus_rdata[HW-1:0] = alm_hi_q;
            A_RAW:   bus_rdata[0]      = raw_q;
            A_IEN:   bus_rdata[0]      = ien_q;
            default: ;
        endcase
    end

    // R3
    snap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q);
    // R3
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> {snap_hi_q, snap_lo_q} == $past(cnt));
    // R6
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw_q);
    // R8
    raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_iclr && bus_wdata[0] && !hit) |=> !raw_q);
endmodule

// File: tb/sim_alarm_timer.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random run segments checked against a cycle model.
module sim_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int vecs = 0;
    int errs = 0;

    alarm_timer u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic load(input logic [53:0] v);
        wr(4'd4, v[31:0]); wr(4'd5, {10'd0, v[53:32]}); wr(4'd6, 32'd0);
    endtask

    task automatic set_alarm(input logic [53:0] v);
        wr(4'd7, v[31:0]); wr(4'd8, {10'd0, v[53:32]});
    endtask

    task automatic snap(output logic [53:0] v);
        logic [31:0] lo, hi;
        wr(4'd1, 32'd1); @(posedge clk);
        rd(4'd2, lo); rd(4'd3, hi);
        v = {hi[21:0], lo};
    endtask

    // Run for m edges: start edge enables, the m-th edge after it stops and disarms.
    task automatic run_seg(input int f, input logic up, au, arm, input int m);
        wr(4'd0, (f << 16) | (32'(arm) << 3) | (32'(au) << 2) | (32'(up) << 1) | 32'd1);
        idle(m - 1);
        wr(4'd0, (f << 16) | (32'(au) << 2) | (32'(up) << 1));
    endtask

    function automatic int dv(input int f);
        if (f == 0) return 65536;
        if (f <= 2) return 2;
        return f;
    endfunction

    // Cycle model of m running edges with the alarm armed at the start.
    task automatic model(input logic [53:0] ld, alm, input logic up, au, input int dvv, m,
                         output logic [53:0] c, output logic r);
        logic am; int pc; logic tk, h;
        am = 1'b1; pc = 0; c = ld; r = 1'b0;
        for (int i = 0; i < m; i++) begin
            tk = (pc == dvv - 1);
            pc = tk ? 0 : pc + 1;
            h = am && (c == alm);
            if (h) begin
                r = 1'b1;
                if (au) c = ld;
                else begin am = 1'b0; if (tk) c = up ? c + 54'd1 : c - 54'd1; end
            end else if (tk) c = up ? c + 54'd1 : c - 54'd1;
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [53:0] v, old, ec;
        logic er;
        void'($urandom(32'd2024));
        idle(3); @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, d); check("R1 ctrl", d, 0);
        rd(4'd9, d); check("R1 raw", d, 0);
        rd(4'd1, d); check("R1 busy", d, 0);
        snap(v);     check("R1 counter", v, 0);
        check("R1 irq", irq, 0);

        // R2 high halves keep 22 bits
        wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, d); check("R2 ldhi width", d, 32'h003F_FFFF);
        wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, d); check("R2 almhi width", d, 32'h003F_FFFF);

        // R2/R3 load then stale snapshot until capture, busy for one cycle
        load(54'h12_3456_789A_BCDE);
        rd(4'd2, d); check("R3 stale lo", d, 0);
        wr(4'd1, 32'd1); rd(4'd1, d); check("R3 busy set", d, 1);
        @(posedge clk); rd(4'd1, d); check("R3 busy clear", d, 0);
        rd(4'd2, d); check("R2 load lo", d, 32'h789A_BCDE);
        rd(4'd3, d); check("R2 load hi", d, 32'h0012_3456);

        // R5 wrap upward and downward with divisor 2 (field 1)
        load(54'h3F_FFFF_FFFF_FFFE); run_seg(1, 1'b1, 1'b0, 1'b0, 8);
        snap(v); check("R5 wrap up", v, 54'd2);
        load(54'd1); run_seg(1, 1'b0, 1'b0, 1'b0, 6);
        snap(v); check("R5 wrap down", v, 54'h3F_FFFF_FFFF_FFFE);

        // R4 field 0 divides by 65536; restart from zero after stop
        load(54'd0); run_seg(0, 1'b1, 1'b0, 1'b0, 65536);
        snap(v); check("R4 div65536", v, 54'd1);
        load(54'd0); run_seg(7, 1'b1, 1'b0, 1'b0, 6); run_seg(7, 1'b1, 1'b0, 1'b0, 6);
        snap(v); check("R4 phase restart", v, 54'd0);

        // R6/R8 one-shot alarm: disarm, raw, level irq, mask, clear
        wr(4'd10, 32'd1);
        load(54'd0); set_alarm(54'd5);
        wr(4'd0, (32'd3 << 16) | 32'hB);
        idle(30);
        rd(4'd0, d); check("R6 disarmed", d[3], 0);
        rd(4'd9, d); check("R6 raw", d, 1);
        check("R8 irq level", irq, 1);
        wr(4'd10, 32'd0); rd(4'd9, d); check("R8 irq masked", irq, 0);
        wr(4'd10, 32'd1); wr(4'd11, 32'd1);
        rd(4'd9, d); check("R8 raw cleared", d, 0);
        check("R8 irq cleared", irq, 0);
        wr(4'd0, 32'd0);

        // R7 periodic mode keeps the arm bit
        load(54'd10); set_alarm(54'd12);
        wr(4'd0, (32'd2 << 16) | 32'hF);
        idle(20);
        rd(4'd0, d); check("R7 stays armed", d[3], 1);
        wr(4'd0, 32'd0); wr(4'd11, 32'd1);

        // R4 R5 R6 R7 random segments against the cycle model
        for (int k = 0; k < 24; k++) begin
            logic [53:0] ld, alm; logic up, au; int f, off, m;
            ld  = {$urandom, $urandom};
            up  = $urandom % 2;
            au  = $urandom % 2;
            f   = 1 + $urandom % 9;
            off = 1 + $urandom % 12;
            m   = 1 + $urandom % 60;
            alm = up ? ld + 54'(off) : ld - 54'(off);
            wr(4'd11, 32'd1);
            load(ld); set_alarm(alm);
            run_seg(f, up, au, 1'b1, m);
            model(ld, alm, up, au, dv(f), m, ec, er);
            snap(v);       check("R7 random count", v, ec);
            rd(4'd9, d);   check("R6 random raw", d, 64'(er));
        end

        summary();
        $finish;
    end
endmodule